// File: doc/BRIEF.md
# CAN CRC-15 Generator and Checker

This block computes the 15-bit CAN frame checksum one bit at a time. The neighbouring bit-level logic removes stuff bits and decodes the frame fields. For every destuffed bit it pulses a valid strobe, and it tags the bit with a region code that says which part of the frame the bit belongs to. The block folds in only the bits from the start-of-frame bit through the last data bit. Stuff bits, and bits tagged as belonging to no region, never reach the register.

In transmit mode the block presents the finished checksum on `tx_bit`, most significant bit first, and moves to the next bit on each CRC-region strobe. In receive mode it compares each incoming CRC-field bit with its own register. After the fifteenth bit it reports completion and a sticky error flag. On a mismatch it also issues a one-cycle error-frame request. The flags stay as they are until the next start-of-frame.

Top module: `can_crc15_unit`

## Requirements
- R1: After reset, `crc_q` is zero and `crc_done`, `crc_err` and `err_frame_req` are all low.
- R2: A valid bit with `frame_start` high starts a new frame, whatever its region code. It restarts the register from zero, folds that bit in, and clears `crc_done`, `crc_err` and the CRC-bit count.
- R3: Each valid bit tagged body (region 2'b01) advances the register by one step of the polynomial 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1). The feedback bit is the input bit XOR `crc_q[14]`. After the last data bit, `crc_q` equals the checksum of the bit sequence, SOF bit included.
- R4: In cycles with `bit_vld` low (stuff bits, idle cycles), `crc_q`, `crc_done` and `crc_err` do not change, whatever `bit_val` and `region` carry.
- R5: Valid bits tagged with region 2'b00 or 2'b11, without `frame_start`, leave `crc_q` and the flags unchanged.
- R6: During the CRC field (region 2'b10), `tx_bit` shows checksum bit 14 before the first CRC-field strobe. Each strobe moves it to the next lower bit, so the 15 bits go out most significant first.
- R7: In receive mode (`tx_mode` low), `crc_done` rises right after the fifteenth CRC-field bit. At that point `crc_err` is high if any received CRC bit differed from the computed one, and low otherwise.
- R8: `err_frame_req` is high for exactly the one cycle in which `crc_err` first rises.
- R9: `crc_done` and `crc_err` hold until the next `frame_start` bit. CRC-field bits beyond the fifteenth, and body bits after the CRC field has begun, are ignored.
- R10: In transmit mode (`tx_mode` high), the sampled CRC-field bits are not compared and `crc_err` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Destuffed bit valid strobe |
| bit_val | input | 1 | Destuffed bit value (bus readback while transmitting) |
| region | input | 2 | Region tag: 01 body, 10 CRC field, 00/11 none |
| frame_start | input | 1 | Marks the valid bit as the start-of-frame bit |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| crc_q | output | 15 | Checksum register (shifts left during the CRC field) |
| tx_bit | output | 1 | CRC bit to transmit next |
| crc_done | output | 1 | Fifteen CRC-field bits processed |
| crc_err | output | 1 | Received CRC mismatch, sticky |
| err_frame_req | output | 1 | One-cycle error-frame request |

## Verification
Two functions can fall in the same cycle. A new start-of-frame bit can arrive with a region code of CRC field, and it must restart the register rather than be compared or shifted. The bench drives every SOF bit with a random region code, including 2'b10, and then checks that the register holds exactly one polynomial step from zero and that both flags are clear. The fifteenth CRC-bit compare, which sets the sticky flag and fires the error pulse, is judged in the same cycle for frames with a single flipped body bit, frames with a single flipped CRC bit, and frames with no corruption.

// File: rtl/can_crc_pkg.sv
package can_crc_pkg;

   typedef enum logic [1:0] {
      RG_NONE = 2'b00,
      RG_BODY = 2'b01,
      RG_CRC  = 2'b10,
      RG_RSVD = 2'b11
   } region_e;

   localparam int unsigned CAN_CRC_W    = 15;
   localparam logic [14:0] CAN_CRC_POLY = 15'h4599;

endpackage

// File: rtl/can_crc_rgdec.sv
module can_crc_rgdec
   import can_crc_pkg::*;
(
   input  logic       bit_vld,
   input  logic       frame_start,
   input  logic [1:0] region,
   output logic       is_start,
   output logic       is_body,
   output logic       is_crc
);

   region_e rg;

   always_comb begin
      rg       = region_e'(region);
      is_start = bit_vld && frame_start;
      is_body  = bit_vld && !frame_start && (rg == RG_BODY);
      is_crc   = bit_vld && !frame_start && (rg == RG_CRC);
   end

endmodule

// File: rtl/can_crc_lfsr.sv
module can_crc_lfsr #(
   parameter int unsigned    W    = 15,
   parameter logic [W-1:0]   POLY = 15'h4599,
   parameter logic [W-1:0]   INIT = '0,
   parameter int unsigned    IMPL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         adv,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] q
);

   logic [W-1:0] src;
   logic [W-1:0] nxt;
   logic         fb;

   assign src = load ? INIT : q;
   assign fb  = din ^ src[W-1];

   generate
      if (IMPL == 0) begin : g_word
         always_comb nxt = {src[W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end else begin : g_bitwise
         for (genvar i = 0; i < W; i++) begin : g_tap
            if (i == 0) begin : g_lsb
               assign nxt[0] = POLY[0] & fb;
            end else begin : g_upper
               assign nxt[i] = src[i-1] ^ (POLY[i] & fb);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= INIT;
      end else if (load || adv) begin
         q <= nxt;
      end else if (shift) begin
         q <= {q[W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/can_crc_fieldctl.sv
module can_crc_fieldctl #(
   parameter int unsigned W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic crc_bit,
   input  logic rx_mode,
   input  logic din,
   input  logic ref_msb,
   output logic body_open,
   output logic shift_en,
   output logic done,
   output logic err,
   output logic err_pulse
);

   localparam int unsigned CW = $clog2(W + 1);

   logic [CW-1:0] cnt;
   logic          mism;
   logic          mism_n;
   logic          last;

   assign body_open = (cnt == '0);
   assign shift_en  = crc_bit && (cnt != CW'(W));
   assign last      = (cnt == CW'(W - 1));
   assign mism_n    = mism | (rx_mode & (din ^ ref_msb));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         mism      <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         err_pulse <= 1'b0;
      end else if (start) begin
         cnt       <= '0;
         mism      <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         err_pulse <= 1'b0;
      end else begin
         err_pulse <= 1'b0;
         if (shift_en) begin
            cnt  <= cnt + 1'b1;
            mism <= mism_n;
            if (last) begin
               done      <= 1'b1;
               err       <= mism_n;
               err_pulse <= mism_n;
            end
         end
      end
   end

endmodule

// File: rtl/can_crc15_unit.sv
module can_crc15_unit #(
   parameter int unsigned  CRC_W = 15,
   parameter logic [14:0]  POLY  = 15'h4599,
   parameter int unsigned  IMPL  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_val,
   input  logic [1:0]       region,
   input  logic             frame_start,
   input  logic             tx_mode,
   output logic [CRC_W-1:0] crc_q,
   output logic             tx_bit,
   output logic             crc_done,
   output logic             crc_err,
   output logic             err_frame_req
);

   generate
      if (CRC_W != 15) begin : g_bad_width
         $error("can_crc15_unit: CRC_W must be 15");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("can_crc15_unit: polynomial must have a constant term");
      end
      if (IMPL > 1) begin : g_bad_impl
         $error("can_crc15_unit: IMPL must be 0 or 1");
      end
   endgenerate

   logic is_start;
   logic is_body;
   logic is_crc;
   logic body_open;
   logic shift_en;

   can_crc_rgdec u_dec (
      .bit_vld     (bit_vld),
      .frame_start (frame_start),
      .region      (region),
      .is_start    (is_start),
      .is_body     (is_body),
      .is_crc      (is_crc)
   );

   can_crc_lfsr #(
      .W    (CRC_W),
      .POLY (POLY[CRC_W-1:0]),
      .INIT ('0),
      .IMPL (IMPL)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (is_start),
      .adv   (is_body && body_open),
      .shift (shift_en),
      .din   (bit_val),
      .q     (crc_q)
   );

   can_crc_fieldctl #(
      .W (CRC_W)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (is_start),
      .crc_bit   (is_crc),
      .rx_mode   (!tx_mode),
      .din       (bit_val),
      .ref_msb   (crc_q[CRC_W-1]),
      .body_open (body_open),
      .shift_en  (shift_en),
      .done      (crc_done),
      .err       (crc_err),
      .err_pulse (err_frame_req)
   );

   assign tx_bit = crc_q[CRC_W-1];

endmodule

// File: rtl/can_crc_chk.sv
module can_crc_chk #(
   parameter int unsigned W = 15
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bit_vld,
   input logic [1:0]   region,
   input logic         frame_start,
   input logic         tx_mode,
   input logic [W-1:0] crc_q,
   input logic         crc_done,
   input logic         crc_err,
   input logic         err_frame_req
);

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> ($stable(crc_q) && $stable(crc_done) && $stable(crc_err)));

   // R5
   nonregion_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && !frame_start && (region == 2'b00 || region == 2'b11))
      |=> ($stable(crc_q) && $stable(crc_done) && $stable(crc_err)));

   // R2
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && frame_start) |=> (!crc_done && !crc_err && !err_frame_req));

   // R7
   err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> crc_done);

   // R8
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_err) |-> err_frame_req);

   // R8
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_frame_req |=> !err_frame_req);

   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_done && !(bit_vld && frame_start)) |=> crc_done);

   // R10
   tx_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && tx_mode && !frame_start) |=> !$rose(crc_err));

endmodule

bind can_crc15_unit can_crc_chk #(.W(CRC_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bit_vld       (bit_vld),
   .region        (region),
   .frame_start   (frame_start),
   .tx_mode       (tx_mode),
   .crc_q         (crc_q),
   .crc_done      (crc_done),
   .crc_err       (crc_err),
   .err_frame_req (err_frame_req)
);

// File: tb/tb_can_crc15_unit.sv
module tb_can_crc15_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bit_vld;
   logic        bit_val;
   logic [1:0]  region;
   logic        frame_start;
   logic        tx_mode;
   logic [14:0] crc_q;
   logic        tx_bit;
   logic        crc_done;
   logic        crc_err;
   logic        err_frame_req;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   can_crc15_unit dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_vld       (bit_vld),
      .bit_val       (bit_val),
      .region        (region),
      .frame_start   (frame_start),
      .tx_mode       (tx_mode),
      .crc_q         (crc_q),
      .tx_bit        (tx_bit),
      .crc_done      (crc_done),
      .crc_err       (crc_err),
      .err_frame_req (err_frame_req)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [14:0] ref_step(input logic [14:0] c, input logic b);
      logic f;
      f = b ^ c[14];
      c = {c[13:0], 1'b0};
      if (f) c = c ^ 15'h4599;
      return c;
   endfunction

   task automatic drive(input logic v, input logic [1:0] rg, input logic fs);
      @(negedge clk);
      bit_vld     = 1'b1;
      bit_val     = v;
      region      = rg;
      frame_start = fs;
      @(negedge clk);
      bit_vld     = 1'b0;
      frame_start = 1'b0;
      bit_val     = 1'($urandom);
      region      = 2'($urandom);
   endtask

   // optional idle cycles or an untagged valid bit; state must not move
   task automatic gap();
      logic [14:0] pre;
      logic        pd, pe;
      int          kind;
      pre  = crc_q;
      pd   = crc_done;
      pe   = crc_err;
      kind = $urandom % 4;
      if (kind == 1) begin
         repeat (1 + $urandom % 3) @(negedge clk);
         chk(crc_q == pre && crc_done == pd && crc_err == pe, "R4",
             "state moved while bit_vld low", crc_q, pre);
      end else if (kind == 2) begin
         drive(1'($urandom), ($urandom % 2) ? 2'b11 : 2'b00, 1'b0);
         chk(crc_q == pre && crc_done == pd && crc_err == pe, "R5",
             "state moved on untagged bit", crc_q, pre);
      end
   endtask

   task automatic run_frame(input int len, input bit tx, input int bad_body,
                            input int bad_crc, input int extra);
      logic [14:0] good;
      logic [14:0] dm;
      logic        b;
      logic        sent;
      logic        exp_err;
      // SOF bit (dominant), random region tag to collide with CRC code
      drive(1'b0, 2'($urandom), 1'b1);
      good = ref_step(15'h0, 1'b0);
      dm   = good;
      chk(crc_q == dm, "R2", "register after SOF", crc_q, dm);
      chk(!crc_done && !crc_err && !err_frame_req, "R2", "flags after SOF",
          {crc_done, crc_err, err_frame_req}, 0);
      tx_mode = tx;
      for (int i = 1; i <= len; i++) begin
         b    = 1'($urandom);
         good = ref_step(good, b);
         dm   = ref_step(dm, b ^ (i == bad_body));
         drive(b ^ (i == bad_body), 2'b01, 1'b0);
         gap();
      end
      chk(crc_q == dm, "R3", "checksum after last data bit", crc_q, dm);
      for (int k = 0; k < 15; k++) begin
         if (tx) chk(tx_bit == dm[14-k], "R6", "transmit bit order", tx_bit, dm[14-k]);
         sent = tx ? 1'($urandom) : (good[14-k] ^ (k == bad_crc));
         drive(sent, 2'b10, 1'b0);
         if (k == 7) begin
            drive(1'($urandom), 2'b01, 1'b0);   // late body bit: ignored
            chk(crc_done == 1'b0, "R9", "done early", crc_done, 0);
         end
         if (k < 14) gap();
      end
      exp_err = !tx && (bad_body > 0 || bad_crc >= 0);
      chk(crc_done == 1'b1, "R7", "done after 15 CRC bits", crc_done, 1);
      chk(crc_err == exp_err, tx ? "R10" : "R7", "crc_err", crc_err, exp_err);
      chk(err_frame_req == exp_err, "R8", "error request pulse", err_frame_req, exp_err);
      @(negedge clk);
      chk(err_frame_req == 1'b0, "R8", "error request width", err_frame_req, 0);
      for (int e = 0; e < extra; e++) drive(1'($urandom), 2'b10, 1'b0);
      repeat (2) @(negedge clk);
      chk(crc_done == 1'b1 && crc_err == exp_err, "R9", "flags held",
          {crc_done, crc_err}, {1'b1, exp_err});
   endtask

   initial begin
      #1500000;
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h1a2b3c);
      rst_n = 1'b0; bit_vld = 1'b0; bit_val = 1'b0; region = 2'b00;
      frame_start = 1'b0; tx_mode = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(crc_q == 15'h0 && !crc_done && !crc_err && !err_frame_req, "R1",
          "reset state", crc_q, 0);
      // directed corners
      run_frame(0, 1'b0, 0, -1, 0);
      run_frame(0, 1'b1, 0, -1, 2);
      run_frame(100, 1'b0, 0, 14, 3);
      run_frame(100, 1'b0, 0, 0, 0);
      run_frame(64, 1'b1, 0, -1, 1);
      // random frames
      for (int f = 0; f < 60; f++) begin
         int len, sel;
         len = 1 + $urandom % 100;
         sel = $urandom % 4;
         case (sel)
            0: run_frame(len, 1'b1, 0, -1, $urandom % 3);
            1: run_frame(len, 1'b0, 1 + $urandom % len, -1, $urandom % 3);
            2: run_frame(len, 1'b0, 0, $urandom % 15, $urandom % 3);
            default: run_frame(len, 1'b0, 0, -1, $urandom % 3);
         endcase
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule